// File: doc/BRIEF.md
# Preloaded Overflow Error Counter Pair

This block keeps two independent event counters, one for OFDM timing errors and one for CCK timing errors. Each counter is armed with a preload value that sits a programmable number of events below the point where its top bit turns on. The threshold test is the counter's own overflow, so no comparator is needed on the count path. When either counter's top bit is set, a shared level interrupt request is raised.

Software reaches the counters and their enable masks through a small register port. A harvest strobe reloads both counters. In the same edge it recovers how many events each counter saw since it was last loaded and publishes both counts for one cycle. It flags the harvest as "nothing new" when neither count is positive, which is the case for a redundant second interrupt. Positive counts are added into saturating per-period and lifetime accumulators. A disable strobe zeroes both counters and both masks.

Top module: `err_ovf_counter_pair`

## Requirements
- R1: After reset both counters and both masks read zero, `irq` is low, `harv_valid` is low and all four accumulators are zero.
- R2: A counter increments by one, modulo 2^CNT_W, on each cycle its event strobe is high while its mask register is nonzero. With a zero mask the strobe is ignored and the counter keeps its value.
- R3: `irq` is high exactly while bit CNT_W-1 of either counter is set. Starting from the preload value, that happens after TRIG events of that type.
- R4: A harvest loads each counter with FULL-TRIG, where FULL = 2^(CNT_W-1). An event strobe of an enabled counter in the same cycle is counted on top of the reload, giving FULL-TRIG+1.
- R5: One cycle after a harvest, `harv_valid` pulses for one cycle. `harv_ofdm` and `harv_cck` then carry the signed value TRIG-(FULL-v), where v is the counter value just before the reload.
- R6: `harv_new` is low in the valid cycle when both harvested counts are zero or negative, and high otherwise.
- R7: On a harvest, each count that is positive is added to that type's period and lifetime accumulators, saturating at 2^ACC_W-1. A zero or negative count leaves them unchanged.
- R8: `period_clr` zeroes both period accumulators and `life_clr` zeroes both lifetime accumulators. When a clear coincides with a harvest, the accumulator takes the clear and then the harvested count.
- R9: `disable_req` zeroes both counters and both masks. It takes priority over a harvest, which is then dropped (no `harv_valid` pulse), over register writes and over event strobes.
- R10: A register write with `reg_addr` 0 or 1 loads the OFDM or CCK counter, and one with address 2 or 3 loads the OFDM or CCK mask. A counter write overrides an event strobe in the same cycle. `rd_data` shows the register selected by `rd_addr` (same map) combinationally.
- R11: When a harvest and a counter write coincide, the reload wins. A mask write in the harvest cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ofdm_evt | input | 1 | One-cycle OFDM timing error strobe |
| cck_evt | input | 1 | One-cycle CCK timing error strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Write address: 0 OFDM count, 1 CCK count, 2 OFDM mask, 3 CCK mask |
| reg_wdata | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | CNT_W | Selected register contents |
| harvest | input | 1 | Read-and-reload request |
| disable_req | input | 1 | Zero counters and masks |
| period_clr | input | 1 | Clear period accumulators |
| life_clr | input | 1 | Clear lifetime accumulators |
| irq | output | 1 | Level interrupt, either counter overflowed |
| harv_valid | output | 1 | Harvest results valid |
| harv_new | output | 1 | At least one harvested count positive |
| harv_ofdm | output | CNT_W+1 | Signed OFDM events since last load |
| harv_cck | output | CNT_W+1 | Signed CCK events since last load |
| period_ofdm | output | ACC_W | OFDM per-period accumulator |
| period_cck | output | ACC_W | CCK per-period accumulator |
| life_ofdm | output | ACC_W | OFDM lifetime accumulator |
| life_cck | output | ACC_W | CCK lifetime accumulator |

## Verification
Some properties are checked on every cycle. A harvest always drops `irq` and produces a valid pulse one cycle later. A "nothing new" result never carries a positive count. A disable leaves counters and masks at zero. A zero mask freezes its counter. Lifetime totals never shrink without a clear. A rising `irq` always has an event or a write just before it. Some behaviour shows only in the bench's scenarios: the exact harvested arithmetic on counter values written by software, accumulator saturation, the tie rules when a clear, write, event and reload share a cycle, and the threshold count at which the interrupt first appears.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    ADDR_OFDM_CNT  = 2'd0,
    ADDR_CCK_CNT   = 2'd1,
    ADDR_OFDM_MASK = 2'd2,
    ADDR_CCK_MASK  = 2'd3
  } epc_addr_e;

  function automatic logic [1:0] cnt_addr(input int ch);
    return (ch == 0) ? ADDR_OFDM_CNT : ADDR_CCK_CNT;
  endfunction

  function automatic logic [1:0] mask_addr(input int ch);
    return (ch == 0) ? ADDR_OFDM_MASK : ADDR_CCK_MASK;
  endfunction
endpackage

// File: rtl/epc_counter.sv
module epc_counter #(
  parameter int CNT_W = 32,
  parameter int TRIG  = 500
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_i,
  input  logic                    dis_i,
  input  logic                    reload_i,
  input  logic                    cnt_wr_i,
  input  logic                    mask_wr_i,
  input  logic [CNT_W-1:0]        wdata_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [CNT_W-1:0]        mask_o,
  output logic                    ovf_o,
  output logic signed [CNT_W:0]   delta_o
);
  localparam logic [CNT_W:0]   FULL_W  = (CNT_W+1)'(1) << (CNT_W-1);
  localparam logic [CNT_W:0]   TRIG_W  = (CNT_W+1)'(TRIG);
  localparam logic [CNT_W-1:0] PRELOAD = CNT_W'(FULL_W - TRIG_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask_q;
  logic             count_en;

  // events since load: trigger minus the distance still left to full scale
  function automatic logic signed [CNT_W:0] events_since_load(input logic [CNT_W-1:0] v);
    logic [CNT_W:0] remaining;
    remaining = FULL_W - {1'b0, v};
    return $signed(TRIG_W - remaining);
  endfunction

  assign count_en = evt_i && (mask_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (dis_i) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      if (reload_i)      cnt_q <= PRELOAD + CNT_W'(count_en);
      else if (cnt_wr_i) cnt_q <= wdata_i;
      else if (count_en) cnt_q <= cnt_q + CNT_W'(1);
      if (mask_wr_i)     mask_q <= wdata_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign mask_o  = mask_q;
  assign ovf_o   = cnt_q[CNT_W-1];
  assign delta_o = events_since_load(cnt_q);
endmodule

// File: rtl/epc_accum.sv
module epc_accum #(
  parameter int ACC_W = 32,
  parameter int DW    = 33
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 add_i,
  input  logic signed [DW-1:0] delta_i,
  output logic [ACC_W-1:0]     acc_o
);
  localparam int          SW      = ((ACC_W > DW) ? ACC_W : DW) + 1;
  localparam logic [SW-1:0] MAX_W = SW'({ACC_W{1'b1}});

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                                input logic signed [DW-1:0] d);
    logic [SW-1:0] sum;
    if (d <= 0) return a;
    sum = SW'(a) + SW'(unsigned'(d));
    if (sum > MAX_W) return {ACC_W{1'b1}};
    return sum[ACC_W-1:0];
  endfunction

  assign base = clr_i ? '0 : acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (add_i) acc_q <= sat_add(base, delta_i);
    else            acc_q <= base;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/err_ovf_counter_pair.sv
module err_ovf_counter_pair #(
  parameter int CNT_W     = 32,
  parameter int ACC_W     = 32,
  parameter int OFDM_TRIG = 500,
  parameter int CCK_TRIG  = 200
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ofdm_evt,
  input  logic                  cck_evt,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [CNT_W-1:0]      reg_wdata,
  input  logic [1:0]            rd_addr,
  output logic [CNT_W-1:0]      rd_data,
  input  logic                  harvest,
  input  logic                  disable_req,
  input  logic                  period_clr,
  input  logic                  life_clr,
  output logic                  irq,
  output logic                  harv_valid,
  output logic                  harv_new,
  output logic signed [CNT_W:0] harv_ofdm,
  output logic signed [CNT_W:0] harv_cck,
  output logic [ACC_W-1:0]      period_ofdm,
  output logic [ACC_W-1:0]      period_cck,
  output logic [ACC_W-1:0]      life_ofdm,
  output logic [ACC_W-1:0]      life_cck
);
  import epc_pkg::*;
  localparam int DW = CNT_W + 1;

  logic                   harvest_go;
  logic [NUM_CH-1:0]      evt_v;
  logic [NUM_CH-1:0]      ovf_v;
  logic [CNT_W-1:0]       cnt_v   [NUM_CH];
  logic [CNT_W-1:0]       mask_v  [NUM_CH];
  logic signed [DW-1:0]   delta_v [NUM_CH];
  logic signed [DW-1:0]   harv_q  [NUM_CH];
  logic [ACC_W-1:0]       per_v   [NUM_CH];
  logic [ACC_W-1:0]       life_v  [NUM_CH];
  logic                   valid_q;
  logic                   new_q;

  // named internal events for the checker
  logic [CNT_W-1:0] ofdm_cnt, cck_cnt, ofdm_mask, cck_mask;

  assign harvest_go = harvest && !disable_req;
  assign evt_v      = {cck_evt, ofdm_evt};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int TRIG_CH = (ch == 0) ? OFDM_TRIG : CCK_TRIG;

    epc_counter #(.CNT_W(CNT_W), .TRIG(TRIG_CH)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_v[ch]),
      .dis_i     (disable_req),
      .reload_i  (harvest_go),
      .cnt_wr_i  (reg_wr && (reg_addr == cnt_addr(ch))),
      .mask_wr_i (reg_wr && (reg_addr == mask_addr(ch))),
      .wdata_i   (reg_wdata),
      .cnt_o     (cnt_v[ch]),
      .mask_o    (mask_v[ch]),
      .ovf_o     (ovf_v[ch]),
      .delta_o   (delta_v[ch])
    );

    epc_accum #(.ACC_W(ACC_W), .DW(DW)) u_per (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (period_clr),
      .add_i   (harvest_go),
      .delta_i (delta_v[ch]),
      .acc_o   (per_v[ch])
    );

    epc_accum #(.ACC_W(ACC_W), .DW(DW)) u_life (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (life_clr),
      .add_i   (harvest_go),
      .delta_i (delta_v[ch]),
      .acc_o   (life_v[ch])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)          harv_q[ch] <= '0;
      else if (harvest_go) harv_q[ch] <= delta_v[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      new_q   <= 1'b0;
    end else begin
      valid_q <= harvest_go;
      if (harvest_go) new_q <= (delta_v[0] > 0) || (delta_v[1] > 0);
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_OFDM_CNT:  rd_data = cnt_v[0];
      ADDR_CCK_CNT:   rd_data = cnt_v[1];
      ADDR_OFDM_MASK: rd_data = mask_v[0];
      default:        rd_data = mask_v[1];
    endcase
  end

  assign ofdm_cnt    = cnt_v[0];
  assign cck_cnt     = cnt_v[1];
  assign ofdm_mask   = mask_v[0];
  assign cck_mask    = mask_v[1];
  assign irq         = |ovf_v;
  assign harv_valid  = valid_q;
  assign harv_new    = new_q;
  assign harv_ofdm   = harv_q[0];
  assign harv_cck    = harv_q[1];
  assign period_ofdm = per_v[0];
  assign period_cck  = per_v[1];
  assign life_ofdm   = life_v[0];
  assign life_cck    = life_v[1];
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int CNT_W = 32,
  parameter int ACC_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ofdm_evt,
  input logic                  cck_evt,
  input logic                  reg_wr,
  input logic [1:0]            reg_addr,
  input logic                  harvest_go,
  input logic                  disable_req,
  input logic                  period_clr,
  input logic                  life_clr,
  input logic                  irq,
  input logic                  harv_valid,
  input logic                  harv_new,
  input logic signed [CNT_W:0] harv_ofdm,
  input logic signed [CNT_W:0] harv_cck,
  input logic [ACC_W-1:0]      period_ofdm,
  input logic [ACC_W-1:0]      period_cck,
  input logic [ACC_W-1:0]      life_ofdm,
  input logic [CNT_W-1:0]      ofdm_cnt,
  input logic [CNT_W-1:0]      cck_cnt,
  input logic [CNT_W-1:0]      ofdm_mask,
  input logic [CNT_W-1:0]      cck_mask
);
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ofdm_evt) || $past(cck_evt) || $past(reg_wr))); // R3
  AST_RELOAD_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    harvest_go |=> !irq); // R4
  AST_HARVEST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    harvest_go |=> harv_valid); // R5
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !harvest_go |=> !harv_valid); // R5
  AST_NOTHING_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (harv_valid && !harv_new) |-> (harv_ofdm <= 0 && harv_cck <= 0)); // R6
  AST_MASK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (ofdm_mask == '0 && !harvest_go && !disable_req && !(reg_wr && reg_addr == 2'd0))
      |=> $stable(ofdm_cnt)); // R2
  AST_LIFE_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    !life_clr |=> (life_ofdm >= $past(life_ofdm))); // R7
  AST_PERIOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (period_clr && !harvest_go) |=> (period_ofdm == '0 && period_cck == '0)); // R8
  AST_DISABLE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    disable_req |=> (ofdm_cnt == '0 && cck_cnt == '0 && ofdm_mask == '0 && cck_mask == '0)); // R9
endmodule

bind err_ovf_counter_pair epc_checker #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ofdm_evt    (ofdm_evt),
  .cck_evt     (cck_evt),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .harvest_go  (harvest_go),
  .disable_req (disable_req),
  .period_clr  (period_clr),
  .life_clr    (life_clr),
  .irq         (irq),
  .harv_valid  (harv_valid),
  .harv_new    (harv_new),
  .harv_ofdm   (harv_ofdm),
  .harv_cck    (harv_cck),
  .period_ofdm (period_ofdm),
  .period_cck  (period_cck),
  .life_ofdm   (life_ofdm),
  .ofdm_cnt    (ofdm_cnt),
  .cck_cnt     (cck_cnt),
  .ofdm_mask   (ofdm_mask),
  .cck_mask    (cck_mask)
);

// File: tb/sim_err_ovf_counter_pair.sv
`timescale 1ns/1ps
module sim_err_ovf_counter_pair;
  localparam int     CNT_W = 32;
  localparam int     ACC_W = 32;
  localparam longint TRIG0 = 500;
  localparam longint TRIG1 = 200;
  localparam longint FULL  = 64'h8000_0000;
  localparam longint WRAP  = 64'h1_0000_0000;
  localparam longint AMAX  = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ofdm_evt = 0, cck_evt = 0, reg_wr = 0, harvest = 0, disable_req = 0;
  logic period_clr = 0, life_clr = 0;
  logic [1:0] reg_addr = 0, rd_addr = 0;
  logic [CNT_W-1:0] reg_wdata = 0;
  logic [CNT_W-1:0] rd_data;
  logic irq, harv_valid, harv_new;
  logic signed [CNT_W:0] harv_ofdm, harv_cck;
  logic [ACC_W-1:0] period_ofdm, period_cck, life_ofdm, life_cck;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  longint m_cnt [2];
  longint m_mask[2];
  longint m_per [2];
  longint m_life[2];
  longint m_hd  [2];
  bit     m_hv, m_hn;

  always #2.5 clk = ~clk;

  err_ovf_counter_pair #(.CNT_W(CNT_W), .ACC_W(ACC_W),
                         .OFDM_TRIG(int'(TRIG0)), .CCK_TRIG(int'(TRIG1))) u0 (
    .clk(clk), .rst_n(rst_n), .ofdm_evt(ofdm_evt), .cck_evt(cck_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .harvest(harvest),
    .disable_req(disable_req), .period_clr(period_clr), .life_clr(life_clr),
    .irq(irq), .harv_valid(harv_valid), .harv_new(harv_new),
    .harv_ofdm(harv_ofdm), .harv_cck(harv_cck),
    .period_ofdm(period_ofdm), .period_cck(period_cck),
    .life_ofdm(life_ofdm), .life_cck(life_cck));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint trig_of(input int ch);
    return (ch == 0) ? TRIG0 : TRIG1;
  endfunction

  function automatic longint sat(input longint a, input longint d);
    if (d <= 0) return a;
    return (a + d > AMAX) ? AMAX : a + d;
  endfunction

  function automatic longint reg_view(input int a);
    case (a)
      0: return m_cnt[0];
      1: return m_cnt[1];
      2: return m_mask[0];
      default: return m_mask[1];
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_mask[c] = 0; m_per[c] = 0; m_life[c] = 0; m_hd[c] = 0;
    end
    m_hv = 0; m_hn = 0;
  endtask

  // reference update for one clock edge, from the requirements
  task automatic model_edge(input bit e0, e1, wr, input int wa, input longint wd,
                            input bit hv, dis, pc, lc);
    bit     ev[2];
    longint d[2];
    bit     go;
    ev[0] = e0; ev[1] = e1;
    go = hv && !dis;
    for (int c = 0; c < 2; c++) d[c] = trig_of(c) - (FULL - m_cnt[c]);
    for (int c = 0; c < 2; c++) begin
      longint bp, bl;
      bit en;
      bp = pc ? 0 : m_per[c];
      bl = lc ? 0 : m_life[c];
      m_per[c]  = go ? sat(bp, d[c]) : bp;
      m_life[c] = go ? sat(bl, d[c]) : bl;
      en = ev[c] && (m_mask[c] != 0);
      if (dis) begin
        m_cnt[c] = 0; m_mask[c] = 0;
      end else begin
        if (go)                m_cnt[c] = FULL - trig_of(c) + (en ? 1 : 0);
        else if (wr && wa == c) m_cnt[c] = wd;
        else if (en)           m_cnt[c] = (m_cnt[c] + 1) % WRAP;
        if (wr && wa == c + 2) m_mask[c] = wd;
      end
    end
    m_hv = go;
    if (go) begin
      m_hd[0] = d[0]; m_hd[1] = d[1];
      m_hn = (d[0] > 0) || (d[1] > 0);
    end
  endtask

  task automatic compare_all(input int ra);
    chk("R10 rd_data", longint'(rd_data), reg_view(ra));
    chk("R3 irq", longint'(irq), longint'((m_cnt[0] >= FULL) || (m_cnt[1] >= FULL)));
    chk("R5 harv_valid", longint'(harv_valid), longint'(m_hv));
    if (m_hv) begin
      chk("R5 harv_ofdm", longint'(harv_ofdm), m_hd[0]);
      chk("R5 harv_cck", longint'(harv_cck), m_hd[1]);
      chk("R6 harv_new", longint'(harv_new), longint'(m_hn));
    end
    chk("R7 period_ofdm", longint'(period_ofdm), m_per[0]);
    chk("R7 period_cck", longint'(period_cck), m_per[1]);
    chk("R7 life_ofdm", longint'(life_ofdm), m_life[0]);
    chk("R7 life_cck", longint'(life_cck), m_life[1]);
  endtask

  task automatic step(input bit e0, e1, wr, input int wa, input longint wd,
                      input bit hv, dis, pc, lc, input int ra);
    @(negedge clk);
    ofdm_evt = e0; cck_evt = e1; reg_wr = wr; reg_addr = 2'(wa);
    reg_wdata = CNT_W'(wd); harvest = hv; disable_req = dis;
    period_clr = pc; life_clr = lc; rd_addr = 2'(ra);
    @(posedge clk);
    model_edge(e0, e1, wr, wa, wd, hv, dis, pc, lc);
    #1;
    compare_all(ra);
  endtask

  task automatic idle(input int ra);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #0.1;
      chk("R1 reset register", longint'(rd_data), 0);
    end
    chk("R1 reset irq", longint'(irq), 0);
    chk("R1 reset valid", longint'(harv_valid), 0);
    chk("R1 reset life", longint'(life_ofdm) + longint'(life_cck), 0);

    // R2 zero mask ignores events
    repeat (5) step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 masked counter", longint'(rd_data), 0);

    // enable both masks, harvest from zero: negative counts, nothing new
    step(0, 0, 1, 2, 1, 0, 0, 0, 0, 2);
    step(0, 0, 1, 3, 32'h80, 0, 0, 0, 0, 3);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R4 preload", longint'(rd_data), FULL - TRIG0);
    idle(0);
    chk("R6 no new from zero", longint'(harv_new), 0);
    chk("R7 negative not added", longint'(period_ofdm), 0);

    // R3 threshold: TRIG0-1 events keep irq low, the next raises it
    for (int i = 0; i < int'(TRIG0) - 1; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 below threshold", longint'(irq), 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 at threshold", longint'(irq), 1);
    step(0, 1, 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R4 irq cleared", longint'(irq), 0);
    chk("R4 event on reload", longint'(rd_data), FULL - TRIG1 + 1);
    idle(0);
    chk("R5 harvested ofdm", longint'(harv_ofdm), TRIG0);
    chk("R6 new flag", longint'(harv_new), 1);
    // redundant second harvest
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    idle(0);
    chk("R6 redundant harvest", longint'(harv_new), 1);

    // R7 saturation through written counters
    for (int k = 0; k < 2; k++) begin
      step(0, 0, 1, 0, AMAX, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    end
    idle(0);
    chk("R7 saturated", longint'(life_ofdm), AMAX);

    // R8 clear together with harvest
    repeat (3) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    chk("R8 clear plus harvest", longint'(period_ofdm), 3);

    // R10 write beats event; R11 harvest beats write, mask write applies
    step(1, 0, 1, 0, 77, 0, 0, 0, 0, 0);
    chk("R10 write over event", longint'(rd_data), 77);
    step(0, 0, 1, 0, 99, 1, 0, 0, 0, 0);
    chk("R11 reload over write", longint'(rd_data), FULL - TRIG0);
    step(0, 0, 1, 2, 5, 1, 0, 0, 0, 2);
    chk("R11 mask write in harvest", longint'(rd_data), 5);

    // R9 disable beats harvest and write
    step(1, 1, 1, 0, 1234, 1, 1, 0, 0, 0);
    chk("R9 counter zeroed", longint'(rd_data), 0);
    idle(2);
    chk("R9 mask zeroed", longint'(rd_data), 0);
    chk("R9 harvest dropped", longint'(harv_valid), 0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      bit wr, hv, dis, pc, lc;
      int wa;
      longint wd;
      wr  = ($urandom % 8) == 0;
      wa  = int'($urandom % 4);
      case ($urandom % 4)
        0: wd = longint'($urandom);
        1: wd = FULL - trig_of(wa % 2) + longint'($urandom % 600);
        2: wd = longint'($urandom % 3);
        default: wd = FULL - 2;
      endcase
      hv  = ($urandom % 16) == 0;
      dis = ($urandom % 300) == 0;
      pc  = ($urandom % 40) == 0;
      lc  = ($urandom % 200) == 0;
      step(($urandom % 3) != 0, ($urandom % 2) == 0, wr, wa, wd, hv, dis, pc, lc,
           int'($urandom % 4));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule